// File: doc/BRIEF.md
# Quantized Dense Layer Engine

This engine evaluates one fully connected layer on signed 8-bit data, one token at a time. A token is a row of `N_IN` activation bytes. Each byte comes in on a ready/valid stream. For each of `N_OUT` output columns, the engine forms the dot product of the token with that column's weight vector in a 32-bit signed accumulator. It then adds the column's 32-bit bias and rescales the sum back to int8.

The rescale multiplies the biased sum by an integer scale in a 64-bit product. It then shifts the product right arithmetically by a shift amount, rounding to nearest with ties going to even. Finally it saturates the value to the symmetric range -127..127.

Weights, biases, the scale and the shift amount are loaded beforehand through a single write port. Results leave on a ready/valid int8 stream in row-major order. A stalled consumer holds the engine at its next emission.

The parameters cover the 160-token by 64-input by 64-output workload that this layer is sized for. The defaults are smaller, so that the weight store stays compact during elaboration.

Top module: `dl_engine`

## Requirements
- R1: For every token, output column j is computed from the sum over k of signed(act[k]) * signed(w[j][k]), kept as a 32-bit signed value.
- R2: The 32-bit signed bias of column j is added, with 32-bit wrap-around, to column j's sum before rescaling.
- R3: The biased sum is multiplied by the signed 32-bit scale in a 64-bit signed product, with no loss before the shift. The product is then shifted right arithmetically by the 6-bit shift amount.
- R4: When the shift amount is nonzero, the discarded fraction rounds to nearest. An exact half rounds to the even result, for example 6/4 -> 2, -2/4 -> 0 and 10/4 -> 2.
- R5: When the shift amount is 0, the product goes to saturation unchanged.
- R6: Results are saturated to -127..127. The value -128 never appears on `out_data`.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_data` keep their values.
- R8: Each token yields exactly `N_OUT` results, in column order 0..N_OUT-1, and all of them come before any result of the next token.
- R9: After reset, `out_valid` is 0 and `in_ready` is 1. `in_ready` drops after `N_IN` accepted bytes. It returns only once all `N_OUT` results of that token have been handed to the output register.
- R10: The write port works as follows when `cfg_we` is 1. `cfg_sel` = 0 writes weight w[j][k] at `cfg_addr` = j*N_IN+k from `cfg_wdata[7:0]`. `cfg_sel` = 1 writes the bias of column `cfg_addr`. `cfg_sel` = 2 writes the scale. `cfg_sel` = 3 writes the shift amount from `cfg_wdata[5:0]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Activation byte valid |
| in_ready | output | 1 | Engine accepts an activation byte |
| in_data | input | 8 | Signed activation byte |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer accepts the result |
| out_data | output | 8 | Signed int8 result |
| cfg_we | input | 1 | Parameter write strobe |
| cfg_sel | input | 2 | Parameter target: 0 weight, 1 bias, 2 scale, 3 shift |
| cfg_addr | input | CFG_AW | Weight index j*N_IN+k, or bias column |
| cfg_wdata | input | 32 | Write data |

## Verification
The layer is tried with four kinds of input:

- **Full-range random tokens and weights under a moderate scale.** These separate correct signed extension and column indexing from off-by-one or sign faults.
- **Zero weights with chosen biases under a shift of 2.** These place the biased sum exactly on halves and quarters of both signs. They tell round-half-even apart from truncation, round-half-up and round-away.
- **Zero weights with a zero shift.** These drive values past +127 and onto -128, exposing a missing pass-through or an asymmetric clamp.
- **A scale near 2^30 with a shift of 36.** This needs the full 64-bit product, and it runs under random output back-pressure. That case also exercises hold stability and row-major ordering while the engine stalls.

// File: rtl/dl_pkg.sv
package dl_pkg;
    localparam int DATA_W  = 8;
    localparam int ACC_W   = 32;
    localparam int PROD_W  = 2 * ACC_W;
    localparam int SHIFT_W = 6;
    localparam int SAT_MAX = 127;

    typedef enum logic [1:0] {
        PH_LOAD = 2'd0,
        PH_MAC  = 2'd1,
        PH_EMIT = 2'd2
    } phase_t;

    typedef enum logic [1:0] {
        SEL_WEIGHT = 2'd0,
        SEL_BIAS   = 2'd1,
        SEL_SCALE  = 2'd2,
        SEL_SHIFT  = 2'd3
    } cfg_sel_t;

    typedef logic signed [DATA_W-1:0] q8_t;
    typedef logic signed [ACC_W-1:0]  acc_t;
endpackage

// File: rtl/dl_param_store.sv
module dl_param_store
    import dl_pkg::*;
#(
    parameter int N_IN  = 16,
    parameter int N_OUT = 16,
    parameter int AW    = 8,
    parameter int KW    = 4,
    parameter int CW    = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                we_i,
    input  logic [1:0]          sel_i,
    input  logic [AW-1:0]       addr_i,
    input  logic [31:0]         wdata_i,
    input  logic [CW-1:0]       rd_col_i,
    input  logic [KW-1:0]       rd_k_i,
    output q8_t                 w_o,
    output acc_t                bias_o,
    output acc_t                scale_o,
    output logic [SHIFT_W-1:0]  shift_o
);
    localparam int DEPTH = N_IN * N_OUT;

    typedef struct packed {
        acc_t               scale;
        logic [SHIFT_W-1:0] shift;
    } knobs_t;

    q8_t    wmem [DEPTH];
    acc_t   bmem [N_OUT];
    knobs_t knobs_d, knobs_q;
    logic [AW-1:0] rd_idx;

    always_comb begin
        knobs_d = knobs_q;
        if (we_i && sel_i == SEL_SCALE) knobs_d.scale = acc_t'(wdata_i);
        if (we_i && sel_i == SEL_SHIFT) knobs_d.shift = wdata_i[SHIFT_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            knobs_q.scale <= acc_t'(1);
            knobs_q.shift <= '0;
        end else begin
            knobs_q <= knobs_d;
        end
    end

    always_ff @(posedge clk) begin
        if (we_i && sel_i == SEL_WEIGHT && int'(addr_i) < DEPTH)
            wmem[addr_i] <= q8_t'(wdata_i[DATA_W-1:0]);
        if (we_i && sel_i == SEL_BIAS && int'(addr_i) < N_OUT)
            bmem[addr_i[CW-1:0]] <= acc_t'(wdata_i);
    end

    always_comb begin
        rd_idx  = AW'(rd_col_i) * AW'(N_IN) + AW'(rd_k_i);
        w_o     = wmem[rd_idx];
        bias_o  = bmem[rd_col_i];
        scale_o = knobs_q.scale;
        shift_o = knobs_q.shift;
    end
endmodule

// File: rtl/dl_requant.sv
module dl_requant
    import dl_pkg::*;
(
    input  acc_t                sum_i,
    input  acc_t                bias_i,
    input  acc_t                scale_i,
    input  logic [SHIFT_W-1:0]  shift_i,
    output q8_t                 q_o
);
    logic signed [PROD_W-1:0] prod, floor_v, frac, mask, half, rnd;
    acc_t biased;
    logic round_up;

    always_comb begin
        biased   = sum_i + bias_i;
        prod     = PROD_W'(biased) * PROD_W'(scale_i);
        mask     = (PROD_W'(1) << shift_i) - PROD_W'(1);
        floor_v  = prod >>> shift_i;
        frac     = prod & mask;
        half     = (shift_i == '0) ? '0 : (PROD_W'(1) << (shift_i - 1'b1));
        round_up = (shift_i != '0) &&
                   ((frac > half) || ((frac == half) && floor_v[0]));
        rnd      = round_up ? floor_v + PROD_W'(1) : floor_v;
        if (rnd > PROD_W'(SAT_MAX))
            q_o = q8_t'(SAT_MAX);
        else if (rnd < -PROD_W'(SAT_MAX))
            q_o = q8_t'(-SAT_MAX);
        else
            q_o = rnd[DATA_W-1:0];
    end
endmodule

// File: rtl/dl_out_buf.sv
module dl_out_buf
    import dl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    input  q8_t  data_i,
    output logic can_load_o,
    input  logic ready_i,
    output logic valid_o,
    output q8_t  data_o
);
    typedef struct packed {
        logic valid;
        q8_t  data;
    } slot_t;

    slot_t slot_d, slot_q;

    always_comb begin
        slot_d     = slot_q;
        can_load_o = !slot_q.valid || ready_i;
        if (slot_q.valid && ready_i) slot_d.valid = 1'b0;
        if (load_i && can_load_o) begin
            slot_d.valid = 1'b1;
            slot_d.data  = data_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) slot_q <= '0;
        else        slot_q <= slot_d;
    end

    assign valid_o = slot_q.valid;
    assign data_o  = slot_q.data;
endmodule

// File: rtl/dl_engine.sv
module dl_engine
    import dl_pkg::*;
#(
    parameter int N_IN   = 16,
    parameter int N_OUT  = 16,
    localparam int KW     = (N_IN  > 1) ? $clog2(N_IN)  : 1,
    localparam int CW     = (N_OUT > 1) ? $clog2(N_OUT) : 1,
    localparam int CFG_AW = (N_IN * N_OUT > 1) ? $clog2(N_IN * N_OUT) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [7:0]        in_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [7:0]        out_data,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [31:0]       cfg_wdata
);
    localparam logic [KW-1:0] K_LAST = KW'(N_IN - 1);
    localparam logic [CW-1:0] C_LAST = CW'(N_OUT - 1);

    typedef struct packed {
        phase_t                        phase;
        logic [KW-1:0]                 k;
        logic [CW-1:0]                 col;
        acc_t                          acc;
        logic [N_IN-1:0][DATA_W-1:0]   acts;
    } core_t;

    core_t core_d, core_q;

    q8_t                w_cur, q_res, a_cur;
    acc_t               bias_cur, scale_cur;
    logic [SHIFT_W-1:0] shift_cur;
    logic signed [15:0] a16, w16, p16;
    logic               emit, can_load;

    dl_param_store #(
        .N_IN(N_IN), .N_OUT(N_OUT), .AW(CFG_AW), .KW(KW), .CW(CW)
    ) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .we_i     (cfg_we),
        .sel_i    (cfg_sel),
        .addr_i   (cfg_addr),
        .wdata_i  (cfg_wdata),
        .rd_col_i (core_q.col),
        .rd_k_i   (core_q.k),
        .w_o      (w_cur),
        .bias_o   (bias_cur),
        .scale_o  (scale_cur),
        .shift_o  (shift_cur)
    );

    dl_requant u_requant (
        .sum_i   (core_q.acc),
        .bias_i  (bias_cur),
        .scale_i (scale_cur),
        .shift_i (shift_cur),
        .q_o     (q_res)
    );

    dl_out_buf u_obuf (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (emit),
        .data_i     (q_res),
        .can_load_o (can_load),
        .ready_i    (out_ready),
        .valid_o    (out_valid),
        .data_o     (out_data)
    );

    always_comb begin
        core_d   = core_q;
        emit     = 1'b0;
        in_ready = (core_q.phase == PH_LOAD);
        a_cur    = q8_t'(core_q.acts[core_q.k]);
        a16      = 16'(a_cur);
        w16      = 16'(w_cur);
        p16      = a16 * w16;
        unique case (core_q.phase)
            PH_LOAD: begin
                if (in_valid) begin
                    core_d.acts[core_q.k] = in_data;
                    if (core_q.k == K_LAST) begin
                        core_d.k     = '0;
                        core_d.col   = '0;
                        core_d.acc   = '0;
                        core_d.phase = PH_MAC;
                    end else begin
                        core_d.k = core_q.k + 1'b1;
                    end
                end
            end
            PH_MAC: begin
                core_d.acc = core_q.acc + ACC_W'(p16);
                if (core_q.k == K_LAST) begin
                    core_d.k     = '0;
                    core_d.phase = PH_EMIT;
                end else begin
                    core_d.k = core_q.k + 1'b1;
                end
            end
            PH_EMIT: begin
                if (can_load) begin
                    emit       = 1'b1;
                    core_d.acc = '0;
                    if (core_q.col == C_LAST) begin
                        core_d.col   = '0;
                        core_d.phase = PH_LOAD;
                    end else begin
                        core_d.col   = core_q.col + 1'b1;
                        core_d.phase = PH_MAC;
                    end
                end
            end
            default: core_d.phase = PH_LOAD;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            core_q       <= '0;
            core_q.phase <= PH_LOAD;
        end else begin
            core_q <= core_d;
        end
    end
endmodule

module dl_engine_chk #(
    parameter int N_IN  = 16,
    parameter int N_OUT = 16
) (
    input logic       clk,
    input logic       rst_n,
    input logic       in_valid,
    input logic       in_ready,
    input logic       out_valid,
    input logic       out_ready,
    input logic [7:0] out_data
);
    int unsigned beat_q, tokens_q, outs_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            beat_q   <= 0;
            tokens_q <= 0;
            outs_q   <= 0;
        end else begin
            if (in_valid && in_ready) begin
                if (beat_q == N_IN - 1) begin
                    beat_q   <= 0;
                    tokens_q <= tokens_q + 1;
                end else begin
                    beat_q <= beat_q + 1;
                end
            end
            if (out_valid && out_ready) outs_q <= outs_q + 1;
        end
    end

    AST_SYM_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_data != 8'h80)); // R6

    AST_HOLD_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> $stable(out_data)); // R7

    AST_HOLD_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> out_valid); // R7

    AST_NO_EARLY_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready) |-> (longint'(outs_q) < longint'(tokens_q) * N_OUT)); // R8

    AST_IN_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> (longint'(outs_q) + longint'(out_valid) == longint'(tokens_q) * N_OUT)); // R9
endmodule

bind dl_engine dl_engine_chk #(.N_IN(N_IN), .N_OUT(N_OUT)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data)
);

// File: tb/tb_dl_engine.sv
`timescale 1ns/1ps
module tb_dl_engine;
    localparam int NI = 16;
    localparam int NO = 16;
    localparam int AW = $clog2(NI * NO);

    logic clk = 1'b0, rst_n = 1'b0;
    logic in_valid = 1'b0, in_ready;
    logic [7:0] in_data = '0;
    logic out_valid, out_ready = 1'b0;
    logic [7:0] out_data;
    logic cfg_we = 1'b0;
    logic [1:0] cfg_sel = '0;
    logic [AW-1:0] cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;

    int n_chk = 0, n_bad = 0;
    byte wt [NO][NI];
    byte act [NI];
    int  bias [NO];
    int  scale_m, shamt;

    always #2.5 clk = ~clk;

    dl_engine #(.N_IN(NI), .N_OUT(NO)) dut (.*);

    task automatic check(string tag, int got, int exp);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    function automatic int model(int col);
        longint s = 0;
        int s32;
        longint p, q, rem, unit;
        for (int k = 0; k < NI; k++) s += longint'(act[k]) * longint'(wt[col][k]);
        s32 = int'(s) + bias[col];
        p = longint'(s32) * longint'(scale_m);
        if (shamt == 0) q = p;
        else begin
            q = p >>> shamt;
            rem = p - (q <<< shamt);
            unit = longint'(1) <<< shamt;
            if (2 * rem > unit || (2 * rem == unit && q[0])) q = q + 1;
        end
        if (q > 127) q = 127;
        if (q < -127) q = -127;
        return int'(q);
    endfunction

    task automatic cfg_write(int sel, int addr, int data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = 2'(sel); cfg_addr = AW'(addr); cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic load_all();
        for (int j = 0; j < NO; j++) begin
            for (int k = 0; k < NI; k++) cfg_write(0, j * NI + k, int'(wt[j][k]) & 8'hFF);
            cfg_write(1, j, bias[j]);
        end
        cfg_write(2, 0, scale_m);
        cfg_write(3, 0, shamt);
    endtask

    task automatic run_token(string tag, bit stall);
        int got = 0;
        bit held = 0;
        logic [7:0] hold_v = '0;
        for (int k = 0; k < NI; k++) begin
            @(negedge clk);
            in_valid = 1'b1; in_data = act[k];
            while (!in_ready) @(negedge clk);
            @(posedge clk);
        end
        @(negedge clk);
        in_valid = 1'b0;
        check({tag, " R9 busy"}, int'(in_ready), 0);
        while (got < NO) begin
            if (got != 0 || held) @(negedge clk);
            else @(negedge clk);
            out_ready = stall ? ($urandom_range(0, 2) != 0) : 1'b1;
            if (out_valid) begin
                if (held) check({tag, " R7 hold"}, int'(out_data), int'(hold_v));
                if (out_ready) begin
                    check($sformatf("%s R8 col %0d", tag, got), int'($signed(out_data)), model(got));
                    got++;
                    held = 0;
                end else begin
                    held = 1; hold_v = out_data;
                end
            end
        end
        @(negedge clk);
        out_ready = 1'b0;
    endtask

    task automatic rand_all(int lo, int hi);
        for (int j = 0; j < NO; j++) begin
            for (int k = 0; k < NI; k++) wt[j][k] = byte'($urandom);
            bias[j] = $urandom_range(0, hi - lo) + lo;
        end
    endtask

    task automatic rand_act();
        for (int k = 0; k < NI; k++) act[k] = byte'($urandom);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        int rb [NO] = '{2, 6, -2, -6, 5, 7, -10, 10, 3, -3, 1, -1, 0, 14, -14, 4};
        int cb [NO] = '{300, -300, -128, 55, 127, -127, 128, -129, 0, 1, -1, 40, 63, -64, 100000, -100000};
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        check("R9 reset out_valid", int'(out_valid), 0);
        check("R9 reset in_ready", int'(in_ready), 1);
        rst_n = 1'b1;

        // R1 R2 R10: random weights, biases and tokens, moderate scale
        rand_all(-20000, 20000);
        scale_m = 3; shamt = 12;
        load_all();
        for (int t = 0; t < 6; t++) begin
            rand_act();
            run_token("R1 R2 random", 1'b0);
        end

        // R10: rewrite one weight and one bias, the change must show up
        wt[3][0] = 8'sd100; bias[5] = -7777;
        cfg_write(0, 3 * NI, 100);
        cfg_write(1, 5, -7777);
        rand_act();
        run_token("R10 rewrite", 1'b0);

        // R4: zero weights, biases on exact halves and quarters, shift 2
        for (int j = 0; j < NO; j++) begin
            for (int k = 0; k < NI; k++) wt[j][k] = 0;
            bias[j] = rb[j];
        end
        scale_m = 1; shamt = 2;
        load_all();
        rand_act();
        run_token("R4 tie", 1'b0);
        check("R4 direct 6/4", model(1), 2);
        check("R4 direct -10/4", model(6), -2);

        // R5 R6: zero shift, values past the limits
        for (int j = 0; j < NO; j++) bias[j] = cb[j];
        scale_m = 1; shamt = 0;
        load_all();
        run_token("R5 R6 clamp", 1'b0);
        scale_m = 3;
        cfg_write(2, 0, 3);
        run_token("R5 scale3", 1'b0);

        // R3 R7 R8: large scale needs 64-bit product, random back-pressure
        rand_all(-100000, 100000);
        scale_m = 32'h3FFF_F001; shamt = 36;
        load_all();
        for (int t = 0; t < 6; t++) begin
            rand_act();
            run_token("R3 R7 bigscale", 1'b1);
        end

        // R7 R8: moderate scale under stall, mixed extreme tokens
        scale_m = 7; shamt = 20;
        cfg_write(2, 0, 7);
        cfg_write(3, 0, 20);
        for (int t = 0; t < 4; t++) begin
            for (int k = 0; k < NI; k++) act[k] = (t[0]) ? -8'sd128 : 8'sd127;
            if (t >= 2) rand_act();
            run_token("R7 R8 stall", 1'b1);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule